// File: doc/BRIEF.md
# I2C Bus Address Scanner

This block is an I2C controller that takes a census of a bus. One strobe on `start` makes it probe every 7-bit address from the lowest to the highest. Each probe is a START condition, one address byte carrying a write direction bit, a ninth clock on which the acknowledge is sampled, and a STOP condition. The block then moves on to the next address. An address that a target acknowledges is streamed out on `found_addr` with a one-cycle `found_valid` strobe. After the last address has been probed, `done` pulses once.

Both bus lines are open-drain. The block only ever pulls a line low, and it releases the line otherwise. It reads the actual line levels back through a synchronizer. The bus rate is set by `speed_sel`, which selects one of three quarter-period lengths measured in system clocks. The defaults give about 100 kHz, 400 kHz and 1 MHz from a 100 MHz clock.

If a target holds SCL low after the block has released it, the high phase does not begin to be timed until SCL is seen high again. This is a plain wait on SCL high and nothing more.

Top module: `i2c_addr_sweep`

## Requirements
- R1: One strobe on `start` while the block is idle produces exactly 128 probes, for addresses 0x00, 0x01, … 0x7F in ascending order. Each probe is one START, nine SCL clocks and one STOP.
- R2: The byte sent in a probe is `{addr[6:0], 1'b0}`, most significant bit first. For example, address 0x50 is sent as 0xA0.
- R3: An address is reported on `found_addr` with `found_valid` high for exactly one cycle if, and only if, SDA is low during the ninth clock of its probe. Reports therefore appear in ascending address order.
- R4: `speed_sel` is latched at `start`. Code 0 or 3 uses `QTR_STD` clocks per quarter period, code 1 uses `QTR_FAST` and code 2 uses `QTR_FASTP`. With no stretching, successive SCL falling edges inside a probe are 4·Q + `SYNC_STAGES` clock cycles apart.
- R5: `scl_drive_low` and `sda_drive_low` are 1 only when the block pulls the line low. Both are 0 while the block is idle, including after `done`.
- R6: Within a probe, SDA changes only while SCL is low. START is SDA falling with SCL high, held for at least 2·Q clocks before SCL falls. STOP is SDA rising with SCL high, at least 2·Q clocks after SCL rose.
- R7: The gap between a STOP and the next START is at least one SCL period, 4·Q + `SYNC_STAGES` clocks.
- R8: `done` pulses for one cycle, exactly once per sweep, after the STOP of the 0x7F probe and after any report for 0x7F.
- R9: A `start` strobe during a sweep is ignored. The speed and the address sequence continue unchanged, and only one `done` follows.
- R10: When a target keeps SCL low after release, the high phase is timed from the sensed rising edge. The SCL high time is then 2·Q clocks plus the synchronizer latency, and probing continues normally.
- R11: While `rst` is high, both drive outputs, `found_valid` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a sweep when the block is idle |
| speed_sel | input | 2 | Rate code: 0 or 3 standard, 1 fast, 2 fast-plus |
| scl_in | input | 1 | Sensed SCL line level |
| sda_in | input | 1 | Sensed SDA line level |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| found_addr | output | 7 | Address that acknowledged |
| found_valid | output | 1 | One-cycle strobe qualifying `found_addr` |
| done | output | 1 | One-cycle pulse at the end of the sweep |

## Verification
The hardest situation to reach from the ports is a target stretching SCL in the middle of a probe. The block has to notice that the released line has not yet risen, wait for it, and then still time a full high phase.

The bench attaches a bus model that joins both drivers as a wired AND. During one sweep this model holds SCL low for twenty clocks after the third bit of the probe to address 0x40. It then measures the resulting high time against the expected synchronizer latency.

A second hard case is a report for 0x7F that directly precedes `done`. It is reached by giving the model an acknowledge map that includes both 0x00 and 0x7F. The same sweep also carries a `start` strobe, issued mid-sweep with a different speed code.

// File: rtl/i2c_sweep_pkg.sv
package i2c_sweep_pkg;
  localparam int ADDR_W   = 7;
  localparam int BYTE_W   = ADDR_W + 1;
  localparam int ACK_SLOT = BYTE_W;   // index of the ninth clock

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_BIT,
    PH_STOP,
    PH_GAP
  } sweep_phase_e;

  localparam logic [1:0] SPD_FAST  = 2'd1;
  localparam logic [1:0] SPD_FASTP = 2'd2;
endpackage

// File: rtl/sweep_sync.sv
module sweep_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) ff <= {STAGES{RST_VAL}};
        else     ff <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) ff <= {STAGES{RST_VAL}};
        else     ff <= {ff[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = ff[STAGES-1];
endmodule

// File: rtl/sweep_qtick.sv
module sweep_qtick
  import i2c_sweep_pkg::*;
#(
  parameter int QTR_STD   = 250,
  parameter int QTR_FAST  = 62,
  parameter int QTR_FASTP = 25
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] speed_i,
  input  logic       run_i,
  input  logic       hold_i,
  output logic       tick_o
);
  localparam int QMAX_A = (QTR_STD > QTR_FAST) ? QTR_STD : QTR_FAST;
  localparam int QMAX   = (QMAX_A > QTR_FASTP) ? QMAX_A : QTR_FASTP;
  localparam int CW     = (QMAX > 1) ? $clog2(QMAX) : 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] reload;

  always_comb begin
    case (speed_i)
      SPD_FAST:  reload = CW'(QTR_FAST - 1);
      SPD_FASTP: reload = CW'(QTR_FASTP - 1);
      default:   reload = CW'(QTR_STD - 1);
    endcase
  end

  assign tick_o = run_i && !hold_i && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)                          cnt <= '0;
    else if (!run_i || hold_i || tick_o) cnt <= reload;
    else                              cnt <= cnt - 1'b1;
  end

  // The first quarter of a sweep starts from a fully primed counter.
  assert_full_first_quarter_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(run_i) |-> (cnt == reload));
endmodule

// File: rtl/sweep_probe_fsm.sv
module sweep_probe_fsm
  import i2c_sweep_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [1:0]        speed_i,
  input  logic              tick_i,
  input  logic              scl_hi_i,
  input  logic              sda_hi_i,
  output logic              run_o,
  output logic              hold_o,
  output logic [1:0]        speed_o,
  output logic              scl_low_o,
  output logic              sda_low_o,
  output logic [ADDR_W-1:0] found_addr_o,
  output logic              found_valid_o,
  output logic              done_o
);
  sweep_phase_e      phase;
  logic [1:0]        qtr;
  logic [3:0]        bitn;
  logic [ADDR_W-1:0] addr;
  logic [1:0]        speed_q;
  logic [BYTE_W-1:0] probe_byte;
  logic              bit_val;

  assign probe_byte = {addr, 1'b0};
  assign bit_val    = (bitn >= 4'(ACK_SLOT)) ? 1'b1 : probe_byte[3'd7 - bitn[2:0]];
  assign run_o      = (phase != PH_IDLE);
  assign hold_o     = ((phase == PH_BIT) || (phase == PH_STOP)) && (qtr == 2'd2) && !scl_hi_i;
  assign speed_o    = (phase == PH_IDLE) ? speed_i : speed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase         <= PH_IDLE;
      qtr           <= '0;
      bitn          <= '0;
      addr          <= '0;
      speed_q       <= '0;
      scl_low_o     <= 1'b0;
      sda_low_o     <= 1'b0;
      found_addr_o  <= '0;
      found_valid_o <= 1'b0;
      done_o        <= 1'b0;
    end else begin
      found_valid_o <= 1'b0;
      done_o        <= 1'b0;
      case (phase)
        PH_IDLE: begin
          scl_low_o <= 1'b0;
          sda_low_o <= 1'b0;
          if (start_i) begin
            speed_q <= speed_i;
            addr    <= '0;
            qtr     <= '0;
            phase   <= PH_START;
          end
        end
        PH_START: if (tick_i) begin
          qtr <= qtr + 1'b1;
          if (qtr == 2'd1) sda_low_o <= 1'b1;
          if (qtr == 2'd3) begin
            scl_low_o <= 1'b1;
            bitn      <= '0;
            phase     <= PH_BIT;
          end
        end
        PH_BIT: if (tick_i) begin
          qtr <= qtr + 1'b1;
          case (qtr)
            2'd0: sda_low_o <= !bit_val;
            2'd1: scl_low_o <= 1'b0;
            2'd3: begin
              scl_low_o <= 1'b1;
              if (bitn == 4'(ACK_SLOT)) begin
                if (!sda_hi_i) begin
                  found_valid_o <= 1'b1;
                  found_addr_o  <= addr;
                end
                phase <= PH_STOP;
              end else begin
                bitn <= bitn + 1'b1;
              end
            end
            default: ;
          endcase
        end
        PH_STOP: if (tick_i) begin
          qtr <= qtr + 1'b1;
          case (qtr)
            2'd0: sda_low_o <= 1'b1;
            2'd1: scl_low_o <= 1'b0;
            2'd3: begin
              sda_low_o <= 1'b0;
              phase     <= PH_GAP;
            end
            default: ;
          endcase
        end
        PH_GAP: if (tick_i) begin
          qtr <= qtr + 1'b1;
          if (qtr == 2'd3) begin
            if (&addr) begin
              done_o <= 1'b1;
              phase  <= PH_IDLE;
            end else begin
              addr  <= addr + 1'b1;
              phase <= PH_START;
            end
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // Data bits may only move SDA while SCL is held low.
  assert_sda_only_with_scl_low_R6: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_BIT && $past(phase) == PH_BIT && sda_low_o != $past(sda_low_o))
      |-> (scl_low_o && $past(scl_low_o)));

  assert_found_one_cycle_R3: assert property (@(posedge clk) disable iff (rst)
    found_valid_o |=> !found_valid_o);

  assert_found_after_ack_slot_R3: assert property (@(posedge clk) disable iff (rst)
    found_valid_o |-> (phase == PH_STOP && $past(phase) == PH_BIT));

  assert_done_one_cycle_R8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_restart_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_IDLE && start_i) |=> $stable(speed_q));

  assert_idle_released_R5: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE && $past(phase) == PH_IDLE) |-> (!scl_low_o && !sda_low_o));
endmodule

// File: rtl/i2c_addr_sweep.sv
module i2c_addr_sweep
  import i2c_sweep_pkg::*;
#(
  parameter int QTR_STD     = 250,
  parameter int QTR_FAST    = 62,
  parameter int QTR_FASTP   = 25,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        speed_sel,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_drive_low,
  output logic              sda_drive_low,
  output logic [ADDR_W-1:0] found_addr,
  output logic              found_valid,
  output logic              done
);
  logic scl_hi, sda_hi, tick, run, hold;
  logic [1:0] speed_eff;

  sweep_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
    .clk(clk), .rst(rst), .d(scl_in), .q(scl_hi));

  sweep_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
    .clk(clk), .rst(rst), .d(sda_in), .q(sda_hi));

  sweep_qtick #(.QTR_STD(QTR_STD), .QTR_FAST(QTR_FAST), .QTR_FASTP(QTR_FASTP)) u_qtick (
    .clk(clk), .rst(rst), .speed_i(speed_eff), .run_i(run), .hold_i(hold), .tick_o(tick));

  sweep_probe_fsm u_fsm (
    .clk(clk), .rst(rst), .start_i(start), .speed_i(speed_sel), .tick_i(tick),
    .scl_hi_i(scl_hi), .sda_hi_i(sda_hi), .run_o(run), .hold_o(hold), .speed_o(speed_eff),
    .scl_low_o(scl_drive_low), .sda_low_o(sda_drive_low),
    .found_addr_o(found_addr), .found_valid_o(found_valid), .done_o(done));
endmodule

// File: tb/i2c_addr_sweep_tb.sv
`timescale 1ns/1ps
module i2c_addr_sweep_tb;
  localparam int QS = 5, QF = 3, QP = 2, SY = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, start;
  logic [1:0] speed_sel;
  logic slv_sda_low = 1'b0, slv_stretch = 1'b0;
  wire  dut_scl_low, dut_sda_low, found_valid, done;
  wire  [6:0] found_addr;
  wire  scl_bus = ~(dut_scl_low | slv_stretch);
  wire  sda_bus = ~(dut_sda_low | slv_sda_low);

  i2c_addr_sweep #(.QTR_STD(QS), .QTR_FAST(QF), .QTR_FASTP(QP), .SYNC_STAGES(SY)) u_dut (
    .clk(clk), .rst(rst), .start(start), .speed_sel(speed_sel),
    .scl_in(scl_bus), .sda_in(sda_bus),
    .scl_drive_low(dut_scl_low), .sda_drive_low(dut_sda_low),
    .found_addr(found_addr), .found_valid(found_valid), .done(done));

  int n_cmp = 0, n_bad = 0;
  logic [127:0] ack_map = '0;
  int cur_q = QS;
  bit chk_period = 1'b0, do_stretch = 1'b0, stretch_armed = 1'b0, stretch_meas = 1'b0;
  int bitc = 0, probe_idx = 0, start_cnt = 0, stop_cnt = 0, viol = 0;
  int per_bad = 0, per_seen = 0, gap_bad = 0, hold_bad = 0, setup_bad = 0, stretch_high = -1;
  bit in_frame = 1'b0, have_stop = 1'b0;
  logic [7:0] shreg = '0;
  time last_fall = 0, start_t = 0, stop_t = 0, rise_t = 0;
  int found_log [128];
  int found_n = 0, dbl = 0, done_cnt = 0, found_at_done = 0, stops_at_done = 0;
  logic prev_fv = 1'b0;
  event stretch_ev;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // Target-side bus model: start/stop detection and acknowledge generation
  always @(negedge sda_bus) if (scl_bus) begin
    if (in_frame) viol++;
    if (have_stop && ($time - stop_t) < time'((4*cur_q+SY)*10)) gap_bad++;
    start_cnt++; in_frame = 1'b1; bitc = 0; start_t = $time;
  end

  always @(posedge sda_bus) if (scl_bus) begin
    if (in_frame) viol++;
    if (($time - rise_t) < time'(2*cur_q*10)) setup_bad++;
    stop_cnt++; stop_t = $time; have_stop = 1'b1;
  end

  always @(posedge scl_bus) begin
    rise_t = $time;
    if (in_frame && bitc < 8) begin
      shreg = {shreg[6:0], sda_bus};
      bitc++;
      if (bitc == 8) begin
        check(shreg == {probe_idx[6:0], 1'b0}, "R1 R2", "probe byte", int'(shreg),
              int'({probe_idx[6:0], 1'b0}));
        probe_idx++;
      end
    end
  end

  always @(negedge scl_bus) begin
    if (stretch_meas) begin stretch_high = int'($time - rise_t); stretch_meas = 1'b0; end
    if (in_frame) begin
      if (bitc == 0) begin
        if (($time - start_t) < time'(2*cur_q*10)) hold_bad++;
      end else if (chk_period) begin
        per_seen++;
        if (($time - last_fall) != time'((4*cur_q+SY)*10)) per_bad++;
      end
      last_fall = $time;
      if (do_stretch && !stretch_armed && probe_idx == 64 && bitc == 3) begin
        stretch_armed = 1'b1; ->stretch_ev;
      end
      if (bitc == 8) begin
        if (ack_map[shreg[7:1]] && !shreg[0]) slv_sda_low = 1'b1;
        bitc = 9;
      end else if (bitc == 9) begin
        slv_sda_low = 1'b0; in_frame = 1'b0;
      end
    end
  end

  always @(stretch_ev) begin
    slv_stretch = 1'b1;
    repeat (20) @(negedge clk);
    slv_stretch = 1'b0;
    stretch_meas = 1'b1;
  end

  always @(negedge clk) begin
    if (found_valid) begin
      if (found_n < 128) found_log[found_n] = int'(found_addr);
      found_n++;
    end
    if (found_valid && prev_fv) dbl++;
    prev_fv = found_valid;
    if (done) begin done_cnt++; found_at_done = found_n; stops_at_done = stop_cnt; end
  end

  task automatic run_sweep(input logic [1:0] spd, input int q, input bit stretch,
                           input bit midstart, input int kind);
    int en;
    for (int a = 0; a < 128; a++) begin
      case (kind)
        0: ack_map[a] = (a % 9 == 4);
        1: ack_map[a] = (a == 0) || (a == 127) || (a % 16 == 10);
        2: ack_map[a] = (a >= 'h48 && a <= 'h4F) || (a == 'h68);
        default: ack_map[a] = 1'b0;
      endcase
    end
    cur_q = q; chk_period = !stretch; do_stretch = stretch; stretch_armed = 1'b0;
    stretch_high = -1; have_stop = 1'b0; probe_idx = 0; start_cnt = 0; stop_cnt = 0;
    viol = 0; per_bad = 0; per_seen = 0; gap_bad = 0; hold_bad = 0; setup_bad = 0;
    found_n = 0; dbl = 0; done_cnt = 0; found_at_done = 0; stops_at_done = 0;
    @(negedge clk); speed_sel = spd; start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (midstart) begin
      repeat (3000) @(negedge clk);
      speed_sel = 2'd2; start = 1'b1;          // R9: must be ignored
      @(negedge clk); start = 1'b0; speed_sel = spd;
    end
    for (int w = 0; w < 60000 && done_cnt == 0; w++) @(negedge clk);
    repeat (40) @(negedge clk);

    en = 0;
    for (int a = 0; a < 128; a++) begin
      if (ack_map[a]) begin
        check((en < found_n) && (found_log[en] == a), "R3", "reported address",
              (en < found_n) ? found_log[en] : -1, a);
        en++;
      end
    end
    check(found_n == en, "R3", "report count", found_n, en);
    check(dbl == 0, "R3", "strobe longer than one cycle", dbl, 0);
    check(probe_idx == 128, "R1", "probes seen", probe_idx, 128);
    check(start_cnt == 128 && stop_cnt == 128, "R1", "START+STOP count", start_cnt + stop_cnt, 256);
    if (chk_period)
      check(per_bad == 0 && per_seen == 9*128, "R4", "SCL period mismatches", per_bad, 0);
    check(viol == 0, "R6", "SDA edges with SCL high in frame", viol, 0);
    check(hold_bad == 0 && setup_bad == 0, "R6", "START hold / STOP setup short", hold_bad + setup_bad, 0);
    check(gap_bad == 0, "R7", "short bus-free gaps", gap_bad, 0);
    check(done_cnt == 1, "R8", "done pulses", done_cnt, 1);
    check(found_at_done == en, "R8", "reports before done", found_at_done, en);
    check(stops_at_done == 128, "R8", "STOPs before done", stops_at_done, 128);
    check(!dut_scl_low && !dut_sda_low, "R5", "drives after done", int'({dut_scl_low, dut_sda_low}), 0);
    if (midstart) begin
      check(per_bad == 0, "R9", "period changed by ignored start", per_bad, 0);
      check(done_cnt == 1 && probe_idx == 128, "R9", "sweep restarted", probe_idx, 128);
    end
    if (stretch)
      check(stretch_high == (2*q+1)*10+5, "R10", "stretched SCL high time ns", stretch_high, (2*q+1)*10+5);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not finish, got 0 expected 1");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1; start = 1'b0; speed_sel = 2'd0;
    repeat (5) @(negedge clk);
    check(!dut_scl_low && !dut_sda_low, "R11", "drives in reset", int'({dut_scl_low, dut_sda_low}), 0);
    check(!found_valid && !done, "R11", "strobes in reset", int'({found_valid, done}), 0);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    check(!dut_scl_low && !dut_sda_low, "R5", "drives when idle", int'({dut_scl_low, dut_sda_low}), 0);

    run_sweep(2'd0, QS, 1'b0, 1'b0, 0);   // standard rate
    run_sweep(2'd1, QF, 1'b0, 1'b1, 1);   // fast rate, 0x00 and 0x7F answer, mid-sweep start
    run_sweep(2'd2, QP, 1'b1, 1'b0, 2);   // fast-plus with SCL stretching
    run_sweep(2'd3, QS, 1'b0, 1'b0, 3);   // code 3 maps to standard, empty bus

    summary();
    $finish;
  end
endmodule